// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that copies a run of elements between one fixed device location and a region of memory. It works in one of two modes, picked when a job is launched. In single-shot mode it takes the device address, memory address, size word and link word straight from its configuration inputs and performs one transfer. In scatter-gather mode it reads four-word descriptors from memory and follows the chain they form. The configured link value names the first descriptor, and that descriptor is read before any data moves.

Every element is moved in two bus accesses through one master port: a read from the source, then a write to the destination. The device address never changes. The memory address advances by the element width after each beat. The low two bits of each link word say whether the chain goes on and whether an interrupt fires when that descriptor is done. A malformed size word stops the whole chain and raises an error pulse together with the interrupt pulse. A two-bit activity code reports what the engine is doing.

Top module: `dma_chain_engine`

## Requirements
- R1: While reset is low and after it is released, the activity code is 0, no bus request is made and neither pulse output is high.
- R2: In single-shot mode a launch moves data using cfg_dev_addr, cfg_mem_addr and cfg_size without reading any descriptor; the activity code never shows 1.
- R3: With dir_to_dev = 1 each beat reads memory and writes the device; with dir_to_dev = 0 each beat reads the device and writes memory. The device address stays fixed and the memory address grows by the element width per beat.
- R4: Size word bits 13:12 choose the element width: code 3 = 1 byte, 2 = 2 bytes, 0 = 4 bytes. mem_width carries 0, 1 or 2 for 1, 2 or 4 bytes, with data LSB-aligned. Bits 11:0 are a byte count, and the number of beats is the count divided by the width, rounded up.
- R5: In scatter-gather mode the descriptor address is cfg_link with bits 1:0 cleared. Its words are fetched as aligned 4-byte reads at offsets 0 (device address), 4 (memory address), 8 (size word) and 12 (link), all before its first data beat. cfg_dev_addr, cfg_mem_addr and cfg_size are ignored.
- R6: Link bits 1:0 are decoded as 0 = end, 1 = end with interrupt, 2 = follow, 3 = follow with interrupt. When following, the next descriptor sits at the link value with bits 1:0 cleared.
- R7: irq_pulse is high for exactly one cycle after the last beat of each descriptor whose link bit 0 is set. The engine goes idle only after an end code.
- R8: A width code of 1, or a count above 0x3FF for 1- or 2-byte widths or above 0x7FF for 4-byte width, makes err_pulse and irq_pulse high together for one cycle. The engine then goes idle with no beat for that descriptor, and the rest of the chain is dropped.
- R9: The activity code is 1 while a descriptor is being fetched, 3 while data is moving, 2 during the one-cycle decode and link steps, and 0 when idle. Writes occur only while it is 3.
- R10: A start pulse while the engine is not idle has no effect on the job in progress or on what follows it.
- R11: A request holds its address, direction and width unchanged until mem_ack is seen.
- R12: In single-shot mode the link bit 1 is never followed; only bit 0 (interrupt) applies.
- R13: A count of zero produces no beats, and the link code is still acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, sampled when idle |
| mode_sg | input | 1 | 1 = scatter-gather, 0 = single-shot |
| dir_to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_dev_addr | input | 32 | Device address for single-shot |
| cfg_mem_addr | input | 32 | Memory address for single-shot |
| cfg_size | input | CNT_W+2 | Width code and byte count for single-shot |
| cfg_link | input | 32 | Link code (single-shot) or first descriptor address (scatter-gather) |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_width | output | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| mem_wdata | output | 32 | Write data, LSB-aligned |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| act_state | output | 2 | Activity code |
| irq_pulse | output | 1 | Completion interrupt pulse |
| err_pulse | output | 1 | Descriptor error pulse |

## Verification
The assertions assume that the bus returns read data in the same cycle as mem_ack and acknowledges only while a request is up. They also assume that start is a clean synchronous pulse. The bench memory model derives mem_ack combinationally from mem_req and a stall pattern that changes on the falling edge, so it never acknowledges an absent request. Every descriptor the bench builds is word-aligned, and every address it uses stays inside the modelled memory, so fetches never wrap into data areas.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
// Shared types and encodings for the linked-descriptor DMA channel.
// Assumes 32-bit bus words; descriptor layout is fixed at four words.
package dma_chain_pkg;

    localparam int WORD_W = 32;

    // Sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_DECODE,
        SQ_READ,
        SQ_WRITE,
        SQ_LINK
    } seq_state_e;

    // Activity codes shown on act_state
    localparam logic [1:0] ACT_IDLE  = 2'd0;
    localparam logic [1:0] ACT_FETCH = 2'd1;
    localparam logic [1:0] ACT_WAIT  = 2'd2;
    localparam logic [1:0] ACT_MOVE  = 2'd3;

    // Width codes inside the size word
    localparam logic [1:0] WC_BYTE = 2'd3;
    localparam logic [1:0] WC_HALF = 2'd2;
    localparam logic [1:0] WC_WORD = 2'd0;

    // Width codes on the bus port
    localparam logic [1:0] BW_1 = 2'd0;
    localparam logic [1:0] BW_2 = 2'd1;
    localparam logic [1:0] BW_4 = 2'd2;

endpackage

// File: rtl/dma_desc_check.sv
`timescale 1ns/1ps
// Decodes the width code of a size word and validates the byte count
// against the limit for that width. Purely combinational.
// Assumes the count occupies the CNT_W bits below the width code.
module dma_desc_check
    import dma_chain_pkg::*;
#(
    parameter int               CNT_W      = 12,
    parameter logic [CNT_W-1:0] NARROW_MAX = CNT_W'(12'h3FF),
    parameter logic [CNT_W-1:0] WIDE_MAX   = CNT_W'(12'h7FF)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       wcode,
    output logic             ok,
    output logic [2:0]       step,
    output logic [1:0]       bus_w
);

    logic [CNT_W-1:0] limit;
    logic             code_ok;

    // Map the width code to beat size, bus code and count limit
    always_comb begin
        code_ok = 1'b1;
        unique case (wcode)
            WC_BYTE: begin step = 3'd1; bus_w = BW_1; limit = NARROW_MAX; end
            WC_HALF: begin step = 3'd2; bus_w = BW_2; limit = NARROW_MAX; end
            WC_WORD: begin step = 3'd4; bus_w = BW_4; limit = WIDE_MAX;   end
            default: begin step = 3'd4; bus_w = BW_4; limit = '0; code_ok = 1'b0; end
        endcase
        ok = code_ok && (count <= limit);
    end

endmodule

// File: rtl/dma_beat_step.sv
`timescale 1ns/1ps
// Computes the memory address and remaining byte count after one beat,
// and flags the final beat of a descriptor. Purely combinational.
// Assumes remain is non-zero whenever the result is used.
module dma_beat_step
    import dma_chain_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [WORD_W-1:0] cur_mem,
    input  logic [CNT_W-1:0]  remain,
    input  logic [2:0]        step,
    output logic [WORD_W-1:0] mem_nxt,
    output logic [CNT_W-1:0]  remain_nxt,
    output logic              last
);

    logic [CNT_W-1:0] step_c;

    // Advance the address and shrink the count by one element
    always_comb begin
        step_c     = CNT_W'(step);
        mem_nxt    = cur_mem + WORD_W'(step);
        last       = (remain <= step_c);
        remain_nxt = last ? '0 : (remain - step_c);
    end

endmodule

// File: rtl/dma_bus_port.sv
`timescale 1ns/1ps
// Drives the master port from the sequencer state: descriptor words,
// source reads and destination writes. Purely combinational.
// Assumes the caller holds all inputs steady until mem_ack.
module dma_bus_port
    import dma_chain_pkg::*;
(
    input  seq_state_e        state,
    input  logic [WORD_W-1:0] fetch_addr,
    input  logic [WORD_W-1:0] dev_addr,
    input  logic [WORD_W-1:0] cur_mem,
    input  logic              to_dev,
    input  logic [1:0]        bus_w,
    input  logic [WORD_W-1:0] hold,
    output logic              req,
    output logic              we,
    output logic [WORD_W-1:0] addr,
    output logic [1:0]        width,
    output logic [WORD_W-1:0] wdata
);

    // Select the access for the current phase
    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = '0;
        width = BW_4;
        wdata = hold;
        unique case (state)
            SQ_FETCH: begin
                req  = 1'b1;
                addr = fetch_addr;
            end
            SQ_READ: begin
                req   = 1'b1;
                addr  = to_dev ? cur_mem : dev_addr;
                width = bus_w;
            end
            SQ_WRITE: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = to_dev ? dev_addr : cur_mem;
                width = bus_w;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_chain_engine.sv
`timescale 1ns/1ps
// One DMA channel: single-shot transfers from configuration inputs, or
// scatter-gather over a linked list of four-word descriptors in memory.
// Assumes read data arrives together with mem_ack and that the bus
// acknowledges only a raised request.
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int               CNT_W      = 12,
    parameter logic [CNT_W-1:0] NARROW_MAX = CNT_W'(12'h3FF),
    parameter logic [CNT_W-1:0] WIDE_MAX   = CNT_W'(12'h7FF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mode_sg,
    input  logic               dir_to_dev,
    input  logic [31:0]        cfg_dev_addr,
    input  logic [31:0]        cfg_mem_addr,
    input  logic [CNT_W+1:0]   cfg_size,
    input  logic [31:0]        cfg_link,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [1:0]         mem_width,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_ack,
    output logic [1:0]         act_state,
    output logic               irq_pulse,
    output logic               err_pulse
);

    localparam int SIZE_W = CNT_W + 2;

    seq_state_e          state_q;
    logic [WORD_W-1:0]   dev_q;
    logic [WORD_W-1:0]   mem_q;
    logic [SIZE_W-1:0]   size_q;
    logic [WORD_W-1:2]   link_ptr_q;
    logic [1:0]          link_code_q;
    logic [WORD_W-1:2]   desc_ptr_q;
    logic [1:0]          widx_q;
    logic [CNT_W-1:0]    remain_q;
    logic [WORD_W-1:0]   hold_q;
    logic                to_dev_q;
    logic                sg_q;

    logic                size_ok;
    logic [2:0]          step;
    logic [1:0]          bus_w;
    logic [WORD_W-1:0]   mem_nxt;
    logic [CNT_W-1:0]    remain_nxt;
    logic                last_beat;
    logic [WORD_W-1:0]   fetch_addr;
    logic [CNT_W-1:0]    size_cnt;
    logic                take;

    assign size_cnt   = size_q[CNT_W-1:0];
    assign fetch_addr = {desc_ptr_q, 2'b00} + {28'd0, widx_q, 2'b00};
    assign take       = mem_req && mem_ack;

    dma_desc_check #(
        .CNT_W      (CNT_W),
        .NARROW_MAX (NARROW_MAX),
        .WIDE_MAX   (WIDE_MAX)
    ) u_check (
        .count (size_cnt),
        .wcode (size_q[CNT_W+1:CNT_W]),
        .ok    (size_ok),
        .step  (step),
        .bus_w (bus_w)
    );

    dma_beat_step #(
        .CNT_W (CNT_W)
    ) u_step (
        .cur_mem    (mem_q),
        .remain     (remain_q),
        .step       (step),
        .mem_nxt    (mem_nxt),
        .remain_nxt (remain_nxt),
        .last       (last_beat)
    );

    dma_bus_port u_port (
        .state      (state_q),
        .fetch_addr (fetch_addr),
        .dev_addr   (dev_q),
        .cur_mem    (mem_q),
        .to_dev     (to_dev_q),
        .bus_w      (bus_w),
        .hold       (hold_q),
        .req        (mem_req),
        .we         (mem_we),
        .addr       (mem_addr),
        .width      (mem_width),
        .wdata      (mem_wdata)
    );

    // Sequencer: launch, descriptor fetch, decode, beats and link walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            dev_q       <= '0;
            mem_q       <= '0;
            size_q      <= '0;
            link_ptr_q  <= '0;
            link_code_q <= '0;
            desc_ptr_q  <= '0;
            widx_q      <= '0;
            remain_q    <= '0;
            hold_q      <= '0;
            to_dev_q    <= 1'b0;
            sg_q        <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        to_dev_q <= dir_to_dev;
                        sg_q     <= mode_sg;
                        if (mode_sg) begin
                            desc_ptr_q <= cfg_link[31:2];
                            widx_q     <= '0;
                            state_q    <= SQ_FETCH;
                        end else begin
                            dev_q       <= cfg_dev_addr;
                            mem_q       <= cfg_mem_addr;
                            size_q      <= cfg_size;
                            link_ptr_q  <= cfg_link[31:2];
                            link_code_q <= cfg_link[1:0];
                            state_q     <= SQ_DECODE;
                        end
                    end
                end
                SQ_FETCH: begin
                    if (take) begin
                        unique case (widx_q)
                            2'd0: dev_q  <= mem_rdata;
                            2'd1: mem_q  <= mem_rdata;
                            2'd2: size_q <= mem_rdata[SIZE_W-1:0];
                            default: begin
                                link_ptr_q  <= mem_rdata[31:2];
                                link_code_q <= mem_rdata[1:0];
                            end
                        endcase
                        widx_q <= widx_q + 2'd1;
                        if (widx_q == 2'd3) state_q <= SQ_DECODE;
                    end
                end
                SQ_DECODE: begin
                    if (!size_ok)             state_q <= SQ_IDLE;
                    else if (size_cnt == '0)  state_q <= SQ_LINK;
                    else begin
                        remain_q <= size_cnt;
                        state_q  <= SQ_READ;
                    end
                end
                SQ_READ: begin
                    if (take) begin
                        hold_q  <= mem_rdata;
                        state_q <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    if (take) begin
                        mem_q    <= mem_nxt;
                        remain_q <= remain_nxt;
                        state_q  <= last_beat ? SQ_LINK : SQ_READ;
                    end
                end
                SQ_LINK: begin
                    if (sg_q && link_code_q[1]) begin
                        desc_ptr_q <= link_ptr_q;
                        widx_q     <= '0;
                        state_q    <= SQ_FETCH;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Activity code and one-cycle pulses from the current state
    always_comb begin
        unique case (state_q)
            SQ_FETCH:                   act_state = ACT_FETCH;
            SQ_DECODE, SQ_LINK:         act_state = ACT_WAIT;
            SQ_READ, SQ_WRITE:          act_state = ACT_MOVE;
            default:                    act_state = ACT_IDLE;
        endcase
        err_pulse = (state_q == SQ_DECODE) && !size_ok;
        irq_pulse = err_pulse || ((state_q == SQ_LINK) && link_code_q[0]);
    end

endmodule

// File: rtl/dma_chain_engine_chk.sv
`timescale 1ns/1ps
// Property checker for dma_chain_engine, attached by bind below.
// Assumes the environment acknowledges only raised requests.
module dma_chain_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_width,
    input logic [1:0]  act_state,
    input logic        irq_pulse,
    input logic        err_pulse
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_state == 2'd0 |-> !mem_req && !irq_pulse && !err_pulse);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_width));

    // R5
    fetch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_state == 2'd1 && mem_req |-> !mem_we && mem_addr[1:0] == 2'b00
                                          && mem_width == 2'd2);

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> act_state == 2'd0);

    // R8
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> irq_pulse);

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R9
    write_in_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> act_state == 2'd3);

endmodule

bind dma_chain_engine dma_chain_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_width (mem_width),
    .act_state (act_state),
    .irq_pulse (irq_pulse),
    .err_pulse (err_pulse)
);

// File: tb/dma_chain_engine_test.sv
`timescale 1ns/1ps
// Self-checking bench: table-driven jobs, then directed chain, abort,
// busy-start, reset and count-limit cases.
module dma_chain_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_sg = 1'b0;
    logic        dir_to_dev = 1'b0;
    logic [31:0] cfg_dev_addr = '0;
    logic [31:0] cfg_mem_addr = '0;
    logic [13:0] cfg_size = '0;
    logic [31:0] cfg_link = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_width, act_state;
    logic        irq_pulse, err_pulse;

    always #4 clk = ~clk;

    dma_chain_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sg(mode_sg),
        .dir_to_dev(dir_to_dev), .cfg_dev_addr(cfg_dev_addr),
        .cfg_mem_addr(cfg_mem_addr), .cfg_size(cfg_size), .cfg_link(cfg_link),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_width(mem_width), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .act_state(act_state), .irq_pulse(irq_pulse),
        .err_pulse(err_pulse)
    );

    localparam logic [31:0] DEV = 32'hF000_0010;

    int n_chk = 0, n_bad = 0;
    logic [7:0]  mem [0:4095];
    logic [31:0] dev_log [0:1023];
    int dev_rd_n = 0, dev_wr_n = 0;
    int n_irq = 0, n_err = 0, n_req_idle = 0;
    int st_cnt [0:3];
    logic stall_en = 1'b0, stall = 1'b0;
    int cyc = 0;
    int b_rd, b_wr, b_irq, b_err;
    int b_st [0:3];

    function automatic int bus_bytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic int wc_bytes(input logic [1:0] c);
        return (c == 2'd3) ? 1 : (c == 2'd2) ? 2 : 4;
    endfunction

    function automatic logic [31:0] dev_val(input int s);
        return 32'h1F2E3D4C + 32'(s) * 32'h01030507;
    endfunction

    function automatic logic [31:0] lane_mask(input int n);
        return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    endfunction

    // Behavioural memory and device port
    logic        dev_hit;
    logic [11:0] wa;
    assign dev_hit = (mem_addr[31:28] == 4'hF);
    assign wa      = mem_addr[11:0];
    assign mem_ack = mem_req && !stall;
    assign mem_rdata = dev_hit ? dev_val(dev_rd_n)
                     : {mem[wa + 12'd3], mem[wa + 12'd2], mem[wa + 12'd1], mem[wa]};

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (dev_hit) begin
                    dev_log[dev_wr_n[9:0]] <= mem_wdata & lane_mask(bus_bytes(mem_width));
                    dev_wr_n <= dev_wr_n + 1;
                end else begin
                    for (int j = 0; j < 4; j++)
                        if (j < bus_bytes(mem_width)) mem[wa + 12'(j)] <= mem_wdata[8*j +: 8];
                end
            end else if (dev_hit) begin
                dev_rd_n <= dev_rd_n + 1;
            end
        end
    end

    // Stall pattern and output monitor, away from the active edge
    always @(negedge clk) begin
        cyc   <= cyc + 1;
        stall <= stall_en && (cyc % 3 == 1);
        if (rst_n) begin
            if (irq_pulse) n_irq <= n_irq + 1;
            if (err_pulse) n_err <= n_err + 1;
            if (act_state == 2'd0 && mem_req) n_req_idle <= n_req_idle + 1;
            st_cnt[act_state] <= st_cnt[act_state] + 1;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int j = 0; j < 4; j++) mem[(a + j) % 4096] = v[8*j +: 8];
    endtask

    task automatic snap();
        b_rd = dev_rd_n; b_wr = dev_wr_n; b_irq = n_irq; b_err = n_err;
        for (int i = 0; i < 4; i++) b_st[i] = st_cnt[i];
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (act_state != 2'd0 && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "job finished in time", (t < 30000), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic launch(input bit sg, input bit dir, input logic [31:0] dv,
                          input logic [31:0] ma, input logic [13:0] sz, input logic [31:0] lk);
        @(negedge clk);
        mode_sg = sg; dir_to_dev = dir; cfg_dev_addr = dv;
        cfg_mem_addr = ma; cfg_size = sz; cfg_link = lk;
        snap();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_dev2mem(input string req, input int ma, input int w, input int beats, input int s0);
        int bad = 0; int ai = 0; logic [7:0] a = 0, e = 0;
        for (int k = 0; k < beats; k++)
            for (int j = 0; j < w; j++) begin
                logic [31:0] v;
                v = dev_val(s0 + k);
                if (bad == 0 && mem[(ma + k * w + j) % 4096] != v[8*j +: 8]) begin
                    bad = 1; ai = ma + k * w + j; a = mem[ai % 4096]; e = v[8*j +: 8];
                end
            end
        chk(req, $sformatf("memory data at %0h", ai), a, e);
    endtask

    task automatic check_mem2dev(input string req, input int ma, input int w, input int beats, input int l0);
        int bad = 0; logic [31:0] a = 0, e = 0;
        for (int k = 0; k < beats; k++) begin
            logic [31:0] v;
            v = 0;
            for (int j = 0; j < w; j++) v[8*j +: 8] = mem[(ma + k * w + j) % 4096];
            if (bad == 0 && dev_log[(l0 + k) % 1024] != v) begin
                bad = 1; a = dev_log[(l0 + k) % 1024]; e = v;
            end
        end
        chk(req, "device write data", a, e);
    endtask

    // Table: {sg, dir, wcode[1:0], count[11:0], link[1:0], stall, exp_err, exp_irq}
    localparam int NV = 10;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 2'd3, 12'd5,     2'd1, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 2'd2, 12'd8,     2'd0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'd0, 12'd16,    2'd3, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 2'd0, 12'd12,    2'd1, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b0, 2'd3, 12'd7,     2'd0, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 2'd1, 12'd4,     2'd0, 1'b0, 1'b1, 1'b1},
        {1'b1, 1'b1, 2'd2, 12'h400,   2'd0, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b0, 2'd0, 12'd0,     2'd1, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 2'd2, 12'd6,     2'd1, 1'b1, 1'b0, 1'b1},
        {1'b0, 1'b1, 2'd0, 12'h800,   2'd0, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 4; i++) st_cnt[i] = 0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "activity in reset", act_state, 0);
        chk("R1", "request in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "activity after reset", act_state, 0);
        chk("R1", "pulses after reset", {irq_pulse, err_pulse}, 0);

        // Table-driven jobs
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            bit sg, dir, xe, xi;
            logic [1:0] wc, lk;
            logic [11:0] cnt;
            int w, beats, ma, s0, l0;
            v = VEC[i];
            sg = v[20]; dir = v[19]; wc = v[18:17]; cnt = v[16:5]; lk = v[4:3];
            stall_en = v[2]; xe = v[1]; xi = v[0];
            w = wc_bytes(wc);
            beats = xe ? 0 : (int'(cnt) + w - 1) / w;
            ma = 32'h100 + i * 32'h40;
            if (sg) begin
                put_word(32'h600, DEV);
                put_word(32'h604, ma);
                put_word(32'h608, {18'd0, wc, cnt});
                put_word(32'h60C, {30'd0, lk});
                launch(1'b1, dir, 32'hF000_0FF0, 32'h0, 14'h1005, 32'h602);
            end else begin
                launch(1'b0, dir, DEV, ma, {wc, cnt}, {30'h1A0, lk});
            end
            s0 = b_rd; l0 = b_wr;
            wait_idle("R9");
            chk(xe ? "R8" : "R7", $sformatf("vec %0d error pulses", i), n_err - b_err, xe);
            chk(xe ? "R8" : "R7", $sformatf("vec %0d irq pulses", i), n_irq - b_irq, xi);
            chk(dir ? "R3" : "R4", $sformatf("vec %0d beats", i),
                dir ? (dev_wr_n - b_wr) : (dev_rd_n - b_rd), beats);
            chk(sg ? "R5" : "R2", $sformatf("vec %0d fetch seen", i), (st_cnt[1] - b_st[1]) > 0, sg);
            chk("R9", $sformatf("vec %0d move seen", i), (st_cnt[3] - b_st[3]) > 0, beats > 0);
            if (cnt == 0) chk("R13", "zero count beats", dev_rd_n - b_rd, 0);
            if (lk == 2'd3 && !sg) chk("R12", "single-shot stops at follow code", act_state, 0);
            if (beats > 0) begin
                if (dir) check_mem2dev("R3", ma, w, beats, l0);
                else     check_dev2mem("R4", ma, w, beats, s0);
            end
        end
        stall_en = 1'b0;

        // R6: three-descriptor chain with mixed codes and widths
        put_word(32'h600, DEV); put_word(32'h604, 32'h400); put_word(32'h608, {18'd0, 2'd3, 12'd3});
        put_word(32'h60C, 32'h640 | 32'd3);
        put_word(32'h640, DEV); put_word(32'h644, 32'h420); put_word(32'h648, {18'd0, 2'd2, 12'd4});
        put_word(32'h64C, 32'h680 | 32'd2);
        put_word(32'h680, DEV); put_word(32'h684, 32'h440); put_word(32'h688, {18'd0, 2'd0, 12'd8});
        put_word(32'h68C, 32'h0 | 32'd1);
        launch(1'b1, 1'b0, 32'h0, 32'h0, 14'h0, 32'h600);
        begin
            int s0;
            s0 = b_rd;
            wait_idle("R6");
            chk("R6", "chain irq count", n_irq - b_irq, 2);
            chk("R6", "chain beats", dev_rd_n - b_rd, 7);
            check_dev2mem("R6", 32'h400, 1, 3, s0);
            check_dev2mem("R6", 32'h420, 2, 2, s0 + 3);
            check_dev2mem("R6", 32'h440, 4, 2, s0 + 5);
        end

        // R8: bad second descriptor drops the rest of the chain
        put_word(32'h600, DEV); put_word(32'h604, 32'h480); put_word(32'h608, {18'd0, 2'd3, 12'd2});
        put_word(32'h60C, 32'h640 | 32'd2);
        put_word(32'h640, DEV); put_word(32'h644, 32'h4A0); put_word(32'h648, {18'd0, 2'd1, 12'd4});
        put_word(32'h64C, 32'h680 | 32'd3);
        put_word(32'h680, DEV); put_word(32'h684, 32'h4C0); put_word(32'h688, {18'd0, 2'd3, 12'd4});
        put_word(32'h68C, 32'd1);
        launch(1'b1, 1'b0, 32'h0, 32'h0, 14'h0, 32'h600);
        wait_idle("R8");
        chk("R8", "abort error pulses", n_err - b_err, 1);
        chk("R8", "abort irq pulses", n_irq - b_irq, 1);
        chk("R8", "abort beats", dev_rd_n - b_rd, 2);
        chk("R8", "later descriptor untouched", mem[12'h4C0], 8'(32'h4C0 * 7 + 3));

        // R10: start while busy is ignored
        stall_en = 1'b1;
        launch(1'b0, 1'b0, DEV, 32'h500, {2'd3, 12'd40}, 32'd0);
        begin
            int s0;
            s0 = b_rd;
            repeat (10) @(negedge clk);
            mode_sg = 1'b1; cfg_link = 32'h600; cfg_mem_addr = 32'h540;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_idle("R10");
            chk("R10", "beats of running job", dev_rd_n - s0, 40);
            check_dev2mem("R10", 32'h500, 1, 40, s0);
            b_irq = n_irq; b_rd = dev_rd_n;
            repeat (20) @(negedge clk);
            chk("R10", "idle after ignored start", act_state, 0);
            chk("R10", "no stray beats", dev_rd_n - b_rd, 0);
            chk("R11", "no request while idle", n_req_idle, 0);
        end
        stall_en = 1'b0;

        // R1: reset in the middle of a job
        launch(1'b0, 1'b0, DEV, 32'h580, {2'd3, 12'd30}, 32'd0);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after mid-job reset", act_state, 0);
        chk("R1", "no request after mid-job reset", mem_req, 0);

        // R8: exact limits are accepted
        launch(1'b0, 1'b0, DEV, 32'h000, {2'd3, 12'h3FF}, 32'd0);
        begin
            int s0;
            s0 = b_rd;
            wait_idle("R8");
            chk("R8", "narrow limit beats", dev_rd_n - s0, 1023);
            chk("R8", "narrow limit no error", n_err - b_err, 0);
            check_dev2mem("R8", 0, 1, 1023, s0);
        end
        launch(1'b0, 1'b0, DEV, 32'h800, {2'd0, 12'h7FF}, 32'd1);
        begin
            int s0;
            s0 = b_rd;
            wait_idle("R8");
            chk("R8", "wide limit beats", dev_rd_n - s0, 512);
            chk("R8", "wide limit no error", n_err - b_err, 0);
            chk("R7", "wide limit irq", n_irq - b_irq, 1);
            check_dev2mem("R8", 32'h800, 4, 512, s0);
        end

        summary();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
    end

endmodule